// File: doc/BRIEF.md
# Receive Frame Status Queue

This block keeps a per-frame record for a bit-oriented (HDLC/SDLC style) receiver whose data bytes are moved out by DMA. While a frame is arriving, a saturating byte counter tallies every received byte. When the receiver flags the end of the frame, the block takes that frame's condition bits and the byte tally, stores them as one word in a small status queue, and restarts the tally for the next frame.

The status queue is separate from the receive data buffer. Because of this, several frames can arrive back to back while software looks at none of them. Software later pops the entries one at a time to learn the length and error state of each frame. If the queue is already full when a frame ends, the new record is dropped and a sticky overflow flag is raised. Recording happens only while the enable input is high.

Top module: `frame_stat_fifo`

## Requirements
- R1: Each stored word carries the 5 frame condition bits from `stat_i` in bits [18:14] and the frame's byte tally in bits [13:0]. The tally is the number of `byte_i` strobes since the previous stored frame, or since enable rose.
- R2: A `byte_i` strobe in the same cycle as `eof_i` belongs to the frame that is closing. The tally of the next frame then starts from zero.
- R3: The byte tally saturates at 16383 and never wraps. The frame after a saturated one counts from zero again.
- R4: While `en_i` is low, `byte_i` and `eof_i` are ignored: nothing is stored and the tally is held at zero.
- R5: The queue holds up to 10 words and returns them in arrival order. `nempty_o` is high exactly while at least one word is held.
- R6: An end of frame that arrives while 10 words are held is dropped. It sets `ovf_o`, which stays high until reset.
- R7: A pop while the queue is empty has no effect, and `head_o` keeps its last value.
- R8: After reset, `nempty_o`, `ovf_o` and `head_o` are all zero.
- R9: When the queue is full, a pop and an end of frame in the same cycle are both accepted, and `ovf_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Recording enable |
| byte_i | input | 1 | One received byte (strobe) |
| eof_i | input | 1 | End of frame (strobe) |
| stat_i | input | 5 | Frame condition bits, sampled with `eof_i` |
| pop_i | input | 1 | Remove the head word (strobe) |
| head_o | output | 19 | Oldest stored word |
| nempty_o | output | 1 | Queue holds at least one word |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Every result is registered. A strobe sampled at one rising edge changes `head_o`, `nempty_o` and `ovf_o` right after that same edge, and no later edge is involved. The bench therefore changes inputs 1 ns after a rising edge and reads outputs 1 ns after the next rising edge, so each check falls inside the cycle in which its result first becomes visible. The tally is seen only through stored words, so every length check pushes a frame and then reads the head.

// File: rtl/fsf_pkg.sv
package fsf_pkg;
  localparam int FSF_CNT_W  = 14;
  localparam int FSF_STAT_W = 5;
  localparam int FSF_DEPTH  = 10;
endpackage

// File: rtl/fsf_byte_counter.sv
module fsf_byte_counter #(
  parameter int CNT_W = fsf_pkg::FSF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             byte_i,
  input  logic             eof_i,
  output logic             push_o,
  output logic [CNT_W-1:0] len_o
);
  localparam logic [CNT_W-1:0] MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  // the byte of this cycle is included, clipped at the top value
  assign cnt_inc = (byte_i && cnt_q != MAX) ? cnt_q + 1'b1 : cnt_q;
  assign len_o   = cnt_inc;
  assign push_o  = en_i && eof_i;

  always_ff @(posedge clk) begin
    if (rst || !en_i || eof_i) cnt_q <= '0;
    else                       cnt_q <= cnt_inc;
  end

  p_sat_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == MAX && byte_i && !eof_i && en_i) |=> (cnt_q == MAX));

  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (cnt_q == '0));

  p_restart_r2: assert property (@(posedge clk) disable iff (rst)
    push_o |=> (cnt_q == '0));
endmodule

// File: rtl/fsf_store.sv
module fsf_store #(
  parameter int W     = fsf_pkg::FSF_CNT_W + fsf_pkg::FSF_STAT_W,
  parameter int DEPTH = fsf_pkg::FSF_DEPTH
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic         nempty_o,
  output logic         ovf_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q, rd_next;
  logic [OCC_W-1:0] occ_q, occ_next;
  logic [W-1:0]     head_q;
  logic             ovf_q;
  logic             do_pop, do_push;

  assign do_pop   = pop_i && (occ_q != '0);
  assign do_push  = push_i && ((occ_q != FULL) || do_pop);
  assign rd_next  = do_pop ? ((rd_q == LAST) ? '0 : rd_q + 1'b1) : rd_q;
  assign occ_next = occ_q + OCC_W'(do_push) - OCC_W'(do_pop);

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= '0;
      rd_q   <= '0;
      occ_q  <= '0;
      head_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      rd_q  <= rd_next;
      occ_q <= occ_next;
      if (push_i && !do_push) ovf_q <= 1'b1;
      if (occ_next != '0)
        head_q <= (do_push && wr_q == rd_next) ? din_i : mem[rd_next];
    end
  end

  assign head_o   = head_q;
  assign nempty_o = (occ_q != '0);
  assign ovf_o    = ovf_q;

  p_occ_bound_r5: assert property (@(posedge clk) disable iff (rst)
    occ_q <= FULL);

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);

  p_pop_empty_r7: assert property (@(posedge clk) disable iff (rst)
    (occ_q == '0 && pop_i && !push_i) |=> ($stable(head_q) && occ_q == '0));

  p_full_swap_r9: assert property (@(posedge clk) disable iff (rst)
    (occ_q == FULL && pop_i && push_i) |=> (occ_q == FULL && $stable(ovf_q)));
endmodule

// File: rtl/frame_stat_fifo.sv
module frame_stat_fifo #(
  parameter int CNT_W  = fsf_pkg::FSF_CNT_W,
  parameter int STAT_W = fsf_pkg::FSF_STAT_W,
  parameter int DEPTH  = fsf_pkg::FSF_DEPTH
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en_i,
  input  logic                      byte_i,
  input  logic                      eof_i,
  input  logic [STAT_W-1:0]         stat_i,
  input  logic                      pop_i,
  output logic [STAT_W+CNT_W-1:0]   head_o,
  output logic                      nempty_o,
  output logic                      ovf_o
);
  localparam int W = STAT_W + CNT_W;

  logic             push;
  logic [CNT_W-1:0] len;

  fsf_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en_i(en_i), .byte_i(byte_i), .eof_i(eof_i),
    .push_o(push), .len_o(len)
  );

  fsf_store #(.W(W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push_i(push), .din_i({stat_i, len}),
    .pop_i(pop_i), .head_o(head_o), .nempty_o(nempty_o), .ovf_o(ovf_o)
  );

  p_push_seen_r1: assert property (@(posedge clk) disable iff (rst)
    (en_i && eof_i) |=> nempty_o);
endmodule

// File: tb/sim_frame_stat_fifo.sv
module sim_frame_stat_fifo;
  logic        clk = 1'b0;
  logic        rst, en_i, byte_i, eof_i, pop_i;
  logic [4:0]  stat_i;
  logic [18:0] head_o;
  logic        nempty_o, ovf_o;
  int          errors = 0;
  int          checks = 0;

  always #2.5 clk = ~clk;

  frame_stat_fifo u0 (
    .clk(clk), .rst(rst), .en_i(en_i), .byte_i(byte_i), .eof_i(eof_i),
    .stat_i(stat_i), .pop_i(pop_i), .head_o(head_o),
    .nempty_o(nempty_o), .ovf_o(ovf_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle with the given strobes, outputs readable on return
  task automatic cyc(logic b, logic e, logic [4:0] s, logic p);
    byte_i = b; eof_i = e; stat_i = s; pop_i = p;
    @(posedge clk); #1;
    byte_i = 0; eof_i = 0; pop_i = 0;
  endtask

  task automatic frame(int n, logic [4:0] s);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0);
    cyc(0, 1, s, 0);
  endtask

  task automatic do_reset();
    rst = 1; en_i = 1; byte_i = 0; eof_i = 0; pop_i = 0; stat_i = 0;
    @(posedge clk); @(posedge clk); #1;
    rst = 0;
  endtask

  task automatic t_reset();
    rst = 1; en_i = 1; byte_i = 0; eof_i = 0; pop_i = 0; stat_i = 0;
    @(posedge clk); #1;
    cyc(1, 1, 5'h1f, 1);
    chk("R8 nempty", nempty_o, 0);
    chk("R8 ovf", ovf_o, 0);
    chk("R8 head", head_o, 0);
    rst = 0;
  endtask

  task automatic t_basic();
    do_reset();
    frame(3, 5'b10101);
    chk("R1 nempty", nempty_o, 1);
    chk("R1 word", head_o, {5'b10101, 14'd3});
    cyc(0, 0, 0, 1);
    chk("R5 empty after pop", nempty_o, 0);
  endtask

  task automatic t_same_cycle();
    do_reset();
    cyc(1, 0, 0, 0);
    cyc(1, 1, 5'h03, 0);
    chk("R2 closing byte counted", head_o, {5'h03, 14'd2});
    cyc(0, 1, 5'h04, 0);
    cyc(0, 0, 0, 1);
    chk("R2 next starts at zero", head_o, {5'h04, 14'd0});
  endtask

  task automatic t_fill_order();
    do_reset();
    for (int i = 0; i < 10; i++) frame(i, 5'(i + 1));
    chk("R5 head is first", head_o, {5'd1, 14'd0});
    frame(7, 5'h1f);
    chk("R6 ovf set", ovf_o, 1);
    for (int i = 0; i < 10; i++) begin
      chk("R5 order", head_o, {5'(i + 1), 14'(i)});
      chk("R5 nempty", nempty_o, 1);
      cyc(0, 0, 0, 1);
    end
    chk("R6 dropped word absent", nempty_o, 0);
    chk("R6 ovf sticky", ovf_o, 1);
    frame(1, 5'h02);
    chk("R6 ovf stays", ovf_o, 1);
  endtask

  task automatic t_pop_empty();
    do_reset();
    frame(4, 5'h09);
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 1);
    chk("R7 still empty", nempty_o, 0);
    chk("R7 head kept", head_o, {5'h09, 14'd4});
    frame(2, 5'h0a);
    chk("R7 later push fine", head_o, {5'h0a, 14'd2});
  endtask

  task automatic t_disabled();
    do_reset();
    cyc(1, 0, 0, 0);
    en_i = 0;
    cyc(1, 0, 0, 0);
    cyc(1, 1, 5'h11, 0);
    chk("R4 no store", nempty_o, 0);
    en_i = 1;
    frame(1, 5'h12);
    chk("R4 tally cleared", head_o, {5'h12, 14'd1});
  endtask

  task automatic t_saturate();
    do_reset();
    frame(16390, 5'h10);
    chk("R3 saturated", head_o, {5'h10, 14'd16383});
    frame(2, 5'h08);
    cyc(0, 0, 0, 1);
    chk("R3 restart", head_o, {5'h08, 14'd2});
  endtask

  task automatic t_full_swap();
    do_reset();
    for (int i = 0; i < 10; i++) frame(0, 5'(i));
    cyc(0, 1, 5'h1e, 1);
    chk("R9 no ovf", ovf_o, 0);
    chk("R9 head advanced", head_o, {5'd1, 14'd0});
    for (int i = 0; i < 9; i++) cyc(0, 0, 0, 1);
    chk("R9 new word kept", head_o, {5'h1e, 14'd0});
    cyc(0, 0, 0, 1);
    chk("R9 drained", nempty_o, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_basic();
        t_same_cycle();
        t_fill_order();
        t_pop_empty();
        t_disabled();
        t_saturate();
        t_full_swap();
      end
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule